// File: doc/BRIEF.md
# Port-IO Configuration Access Unit

This unit sits on the host's I/O-port path. It turns the classic two-port indirection into tagged configuration requests: software first loads an address register with a bus, device, function and register index, then reads or writes a data window. The address register answers only to full 32-bit accesses at `ADDR_PORT`. The data window covers the four ports that start at `DATA_PORT`. While the enable bit (bit 31) of the address register is set, each data-window access becomes one configuration request. That request carries the decoded target fields, per-lane byte enables and the write data. The host's response is held back until the configuration completion arrives.

While the enable bit is clear, data-window accesses are not touched. So are accesses to any port the unit does not claim, and so are narrow accesses to the address register ports. All of them go out unchanged on a plain port-I/O request channel, and that channel's response is relayed back to the host. The unit runs one transaction at a time.

Every data path uses valid/ready. A transfer happens on a clock edge where both are high. A source that raises valid keeps it high, and keeps its payload stable, until that transfer. The unit gives no back-pressure on a response it is waiting for (completion ready is high through the whole wait state), and it accepts a new host request only when it is idle.

Top module: `cfg_portio_unit`

## Requirements
- R1: After reset the address register reads 00000000h, so the enable bit is clear and data-window accesses are forwarded as plain I/O.
- R2: A 32-bit write (size code 2) to `ADDR_PORT` stores bit 31 and bits 23:2. A 32-bit read returns `{en, 7'b0, bus, dev, fn, idx, 2'b00}`: bits 30:24 and 1:0 always read as zero. An address-register write responds with data 0.
- R3: A configuration request carries bus = bits 23:16, device = bits 15:11, function = bits 10:8 and dword index = bits 7:2 of the address register. For example, 8000F8F0h gives bus 0, device 31, function 0, index 3Ch.
- R4: When the enable bit is set, a read or write to any port from `DATA_PORT` to `DATA_PORT+3` issues exactly one configuration request. The request keeps the host's write flag and its lane-positioned 32-bit write data.
- R5: Byte enables follow from size code and port bits 1:0. Byte (code 0) gives `1 << port[1:0]`. Word (code 1) gives 0011b when port bit 1 is 0 and 1100b when it is 1. Dword (code 2 or 3) gives 1111b.
- R6: When the enable bit is clear, a data-window access issues no configuration request. It goes out as one plain I/O request with the same port, write flag, byte enables and data.
- R7: Accesses to ports outside both windows, and byte or word accesses to the address-register ports, go out as plain I/O and leave the address register unchanged.
- R8: A configuration read returns the completion data when the completion's found flag is 1, and FFFFFFFFh when it is 0. A plain I/O read returns the I/O response data. All writes respond with data 0.
- R9: `host_req_ready` is high only when the unit is idle. A pending `cfg_req_valid`, `io_req_valid` or `host_rsp_valid` stays high with a stable payload until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host I/O access valid |
| host_req_ready | output | 1 | Unit accepts a host access (idle) |
| host_req_write | input | 1 | 1 = I/O write, 0 = I/O read |
| host_req_port | input | PORT_W | I/O port address |
| host_req_size | input | 2 | 0 byte, 1 word, 2 dword |
| host_req_wdata | input | 32 | Lane-positioned write data |
| host_rsp_valid | output | 1 | Response to host valid |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | 32 | Read data (0 for writes) |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Configuration request taken |
| cfg_req_write | output | 1 | Configuration write flag |
| cfg_req_bus | output | 8 | Target bus |
| cfg_req_dev | output | 5 | Target device |
| cfg_req_fn | output | 3 | Target function |
| cfg_req_idx | output | 6 | Dword register index |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_wdata | output | 32 | Write data |
| cfg_cpl_valid | input | 1 | Completion valid |
| cfg_cpl_ready | output | 1 | Unit waits for a completion |
| cfg_cpl_found | input | 1 | A device claimed the request |
| cfg_cpl_data | input | 32 | Completion read data |
| io_req_valid | output | 1 | Plain I/O request valid |
| io_req_ready | input | 1 | Plain I/O request taken |
| io_req_write | output | 1 | Plain I/O write flag |
| io_req_port | output | PORT_W | Plain I/O port |
| io_req_be | output | 4 | Plain I/O byte enables |
| io_req_wdata | output | 32 | Plain I/O write data |
| io_rsp_valid | input | 1 | Plain I/O response valid |
| io_rsp_ready | output | 1 | Unit waits for an I/O response |
| io_rsp_data | input | 32 | Plain I/O read data |

## Verification
The bench builds the unit with its default parameters: a 16-bit port space, the address register at 0CF8h and the data window at 0CFCh–0CFFh. With these values it can reach the adjacency corner cases: narrow accesses at 0CF8h that must fall through to plain I/O, every byte and word lane of the window, and unrelated low ports. Its responder models stall the request and response handshakes and report missing devices. This exercises held payloads and the all-ones read on a missing device.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int IDX_W  = 6;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} acc_size_e;
  typedef enum logic [1:0] {RT_ADDR = 2'd0, RT_CFG = 2'd1, RT_IO = 2'd2} route_e;
endpackage

// File: rtl/cfgio_addr_reg.sv
module cfgio_addr_reg
  import cfgio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_enable_bit,
  input  logic [BUS_W-1:0]  wr_bus,
  input  logic [DEV_W-1:0]  wr_dev,
  input  logic [FN_W-1:0]   wr_fn,
  input  logic [IDX_W-1:0]  wr_idx,
  output logic              enable,
  output logic [BUS_W-1:0]  bus,
  output logic [DEV_W-1:0]  dev,
  output logic [FN_W-1:0]   fn,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rd_value
);
  localparam int PAD_W = DATA_W - 1 - BUS_W - DEV_W - FN_W - IDX_W - 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable <= 1'b0;
      bus    <= '0;
      dev    <= '0;
      fn     <= '0;
      idx    <= '0;
    end else if (wr_en) begin
      enable <= wr_enable_bit;
      bus    <= wr_bus;
      dev    <= wr_dev;
      fn     <= wr_fn;
      idx    <= wr_idx;
    end
  end

  assign rd_value = {enable, {PAD_W{1'b0}}, bus, dev, fn, idx, 2'b00};

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_value));
endmodule

// File: rtl/cfgio_lane_decode.sv
module cfgio_lane_decode
  import cfgio_pkg::*;
(
  input  logic [1:0]      port_lo,
  input  logic [1:0]      size,
  output logic [BE_W-1:0] be
);
  always_comb begin
    case (size)
      SZ_BYTE: be = BE_W'(1) << port_lo;
      SZ_WORD: be = port_lo[1] ? 4'b1100 : 4'b0011;
      default: be = '1;
    endcase
  end
endmodule

// File: rtl/cfgio_route_fsm.sv
module cfgio_route_fsm
  import cfgio_pkg::*;
#(
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [PORT_W-1:0] host_req_port,
  input  logic [DATA_W-1:0] host_req_wdata,
  input  route_e            route,
  input  logic [BE_W-1:0]   lane_be,
  input  logic [DATA_W-1:0] addr_value,
  output logic              addr_wr,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_cpl_ready,
  input  logic              cfg_cpl_valid,
  input  logic              cfg_cpl_found,
  input  logic [DATA_W-1:0] cfg_cpl_data,
  output logic              io_req_valid,
  input  logic              io_req_ready,
  output logic              io_rsp_ready,
  input  logic              io_rsp_valid,
  input  logic [DATA_W-1:0] io_rsp_data,
  output logic              req_write,
  output logic [PORT_W-1:0] req_port,
  output logic [BE_W-1:0]   req_be,
  output logic [DATA_W-1:0] req_wdata
);
  typedef enum logic [2:0] {S_IDLE, S_CFG_REQ, S_CFG_WAIT, S_IO_REQ, S_IO_WAIT, S_RSP} state_e;

  state_e            state;
  logic [DATA_W-1:0] rdata_q;
  logic              accept;

  assign accept  = (state == S_IDLE) && host_req_valid;
  assign addr_wr = accept && (route == RT_ADDR) && host_req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rdata_q   <= '0;
      req_write <= 1'b0;
      req_port  <= '0;
      req_be    <= '0;
      req_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (host_req_valid) begin
          req_write <= host_req_write;
          req_port  <= host_req_port;
          req_be    <= lane_be;
          req_wdata <= host_req_wdata;
          case (route)
            RT_ADDR: begin
              rdata_q <= host_req_write ? '0 : addr_value;
              state   <= S_RSP;
            end
            RT_CFG:  state <= S_CFG_REQ;
            default: state <= S_IO_REQ;
          endcase
        end
        S_CFG_REQ: if (cfg_req_ready) state <= S_CFG_WAIT;
        S_CFG_WAIT: if (cfg_cpl_valid) begin
          rdata_q <= req_write ? '0 : (cfg_cpl_found ? cfg_cpl_data : '1);
          state   <= S_RSP;
        end
        S_IO_REQ: if (io_req_ready) state <= S_IO_WAIT;
        S_IO_WAIT: if (io_rsp_valid) begin
          rdata_q <= req_write ? '0 : io_rsp_data;
          state   <= S_RSP;
        end
        S_RSP: if (host_rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign host_req_ready = (state == S_IDLE);
  assign cfg_req_valid  = (state == S_CFG_REQ);
  assign cfg_cpl_ready  = (state == S_CFG_WAIT);
  assign io_req_valid   = (state == S_IO_REQ);
  assign io_rsp_ready   = (state == S_IO_WAIT);
  assign host_rsp_valid = (state == S_RSP);
  assign host_rsp_rdata = rdata_q;

  // R9
  cfg_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(req_be) && $stable(req_wdata));
  // R9
  io_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_valid && !io_req_ready |=> io_req_valid && $stable(req_port) && $stable(req_be));
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid && !host_rsp_ready |=> host_rsp_valid && $stable(host_rsp_rdata));
  // R9
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_req_ready, cfg_req_valid, io_req_valid, host_rsp_valid}));
  // R8
  missing_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cpl_ready && cfg_cpl_valid && !cfg_cpl_found && !req_write |=> host_rsp_rdata == '1);
endmodule

// File: rtl/cfg_portio_unit.sv
module cfg_portio_unit
  import cfgio_pkg::*;
#(
  parameter int               PORT_W    = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [PORT_W-1:0] host_req_port,
  input  logic [1:0]        host_req_size,
  input  logic [31:0]       host_req_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [31:0]       host_rsp_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [7:0]        cfg_req_bus,
  output logic [4:0]        cfg_req_dev,
  output logic [2:0]        cfg_req_fn,
  output logic [5:0]        cfg_req_idx,
  output logic [3:0]        cfg_req_be,
  output logic [31:0]       cfg_req_wdata,
  input  logic              cfg_cpl_valid,
  output logic              cfg_cpl_ready,
  input  logic              cfg_cpl_found,
  input  logic [31:0]       cfg_cpl_data,
  output logic              io_req_valid,
  input  logic              io_req_ready,
  output logic              io_req_write,
  output logic [PORT_W-1:0] io_req_port,
  output logic [3:0]        io_req_be,
  output logic [31:0]       io_req_wdata,
  input  logic              io_rsp_valid,
  output logic              io_rsp_ready,
  input  logic [31:0]       io_rsp_data
);
  logic              en;
  logic [DATA_W-1:0] addr_value;
  logic              addr_wr;
  logic [BE_W-1:0]   lane_be;
  logic              hit_addr, hit_data;
  route_e            route;
  logic              req_write;
  logic [PORT_W-1:0] req_port;
  logic [BE_W-1:0]   req_be;
  logic [DATA_W-1:0] req_wdata;

  assign hit_addr = (host_req_port == ADDR_PORT) && (host_req_size == SZ_DWORD);
  assign hit_data = (host_req_port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);

  always_comb begin
    if (hit_addr)            route = RT_ADDR;
    else if (hit_data && en) route = RT_CFG;
    else                     route = RT_IO;
  end

  cfgio_addr_reg u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(addr_wr),
    .wr_enable_bit(host_req_wdata[31]),
    .wr_bus(host_req_wdata[23:16]), .wr_dev(host_req_wdata[15:11]),
    .wr_fn(host_req_wdata[10:8]), .wr_idx(host_req_wdata[7:2]),
    .enable(en), .bus(cfg_req_bus), .dev(cfg_req_dev), .fn(cfg_req_fn),
    .idx(cfg_req_idx), .rd_value(addr_value)
  );

  cfgio_lane_decode u_lanes (
    .port_lo(host_req_port[1:0]), .size(host_req_size), .be(lane_be)
  );

  cfgio_route_fsm #(.PORT_W(PORT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_port(host_req_port),
    .host_req_wdata(host_req_wdata), .route(route), .lane_be(lane_be),
    .addr_value(addr_value), .addr_wr(addr_wr),
    .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
    .host_rsp_rdata(host_rsp_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_cpl_ready(cfg_cpl_ready), .cfg_cpl_valid(cfg_cpl_valid),
    .cfg_cpl_found(cfg_cpl_found), .cfg_cpl_data(cfg_cpl_data),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_rsp_ready(io_rsp_ready), .io_rsp_valid(io_rsp_valid),
    .io_rsp_data(io_rsp_data),
    .req_write(req_write), .req_port(req_port), .req_be(req_be), .req_wdata(req_wdata)
  );

  assign cfg_req_write = req_write;
  assign cfg_req_be    = req_be;
  assign cfg_req_wdata = req_wdata;
  assign io_req_write  = req_write;
  assign io_req_port   = req_port;
  assign io_req_be     = req_be;
  assign io_req_wdata  = req_wdata;

  // R5
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_valid && host_req_ready && host_req_size == SZ_BYTE |-> $countones(lane_be) == 1);
  // R5
  word_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_valid && host_req_ready && host_req_size == SZ_WORD |-> $countones(lane_be) == 2);
  // R6
  no_cfg_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_valid && host_req_ready && !en |=> !cfg_req_valid);
  // R2
  addr_ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(addr_wr) |-> addr_value[30:24] == 7'd0 && addr_value[1:0] == 2'd0);
endmodule

// File: tb/cfg_portio_unit_bench.sv
module cfg_portio_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic host_req_valid = 0, host_req_write = 0, host_rsp_ready = 0;
  logic [15:0] host_req_port = '0;
  logic [1:0]  host_req_size = '0;
  logic [31:0] host_req_wdata = '0;
  logic host_req_ready, host_rsp_valid;
  logic [31:0] host_rsp_rdata;
  logic cfg_req_valid, cfg_req_write, cfg_cpl_ready;
  logic cfg_req_ready = 1;
  logic [7:0] cfg_req_bus; logic [4:0] cfg_req_dev; logic [2:0] cfg_req_fn;
  logic [5:0] cfg_req_idx; logic [3:0] cfg_req_be; logic [31:0] cfg_req_wdata;
  logic cfg_cpl_valid, cfg_cpl_found; logic [31:0] cfg_cpl_data;
  logic io_req_valid, io_req_write, io_rsp_ready;
  logic io_req_ready = 1;
  logic [15:0] io_req_port; logic [3:0] io_req_be; logic [31:0] io_req_wdata;
  logic io_rsp_valid; logic [31:0] io_rsp_data;

  cfg_portio_unit u_cfg_portio_unit (.*);

  // responder models
  int cfg_cnt, io_cnt;
  logic l_cw; logic [7:0] l_bus; logic [4:0] l_dev; logic [2:0] l_fn; logic [5:0] l_idx;
  logic [3:0] l_cbe; logic [31:0] l_cwd;
  logic l_iw; logic [15:0] l_port; logic [3:0] l_ibe; logic [31:0] l_iwd;

  function automatic logic [31:0] dev_model(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] x);
    return {b, 3'b0, d, 5'b0, f, 2'b0, x};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cfg_cpl_valid <= 0; cfg_cpl_found <= 0; cfg_cpl_data <= '0;
      io_rsp_valid <= 0; io_rsp_data <= '0;
    end else begin
      if (cfg_req_valid && cfg_req_ready) begin
        cfg_cnt <= cfg_cnt + 1;
        l_cw <= cfg_req_write; l_bus <= cfg_req_bus; l_dev <= cfg_req_dev;
        l_fn <= cfg_req_fn; l_idx <= cfg_req_idx; l_cbe <= cfg_req_be; l_cwd <= cfg_req_wdata;
        cfg_cpl_valid <= 1; cfg_cpl_found <= (cfg_req_bus == 8'd0);
        cfg_cpl_data <= dev_model(cfg_req_bus, cfg_req_dev, cfg_req_fn, cfg_req_idx);
      end else if (cfg_cpl_valid && cfg_cpl_ready) cfg_cpl_valid <= 0;
      if (io_req_valid && io_req_ready) begin
        io_cnt <= io_cnt + 1;
        l_iw <= io_req_write; l_port <= io_req_port; l_ibe <= io_req_be; l_iwd <= io_req_wdata;
        io_rsp_valid <= 1; io_rsp_data <= {16'hD00D, io_req_port};
      end else if (io_rsp_valid && io_rsp_ready) io_rsp_valid <= 0;
    end
  end

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [15:0] port, input logic [1:0] sz,
                        input logic [31:0] wd, input int rsp_wait, output logic [31:0] rd);
    logic [31:0] first;
    @(negedge clk);
    host_req_valid = 1; host_req_write = w; host_req_port = port;
    host_req_size = sz; host_req_wdata = wd;
    while (!host_req_ready) @(negedge clk);
    @(posedge clk); #1 host_req_valid = 0;
    @(negedge clk);
    while (!host_rsp_valid) @(negedge clk);
    first = host_rsp_rdata;
    for (int k = 0; k < rsp_wait; k++) begin
      @(negedge clk);
      check(host_rsp_valid && host_rsp_rdata == first, "R9 response held", host_rsp_rdata, first);
    end
    host_rsp_ready = 1;
    rd = host_rsp_rdata;
    @(posedge clk); #1 host_rsp_ready = 0;
  endtask

  typedef struct packed {
    logic w; logic [15:0] port; logic [1:0] sz; logic [31:0] wd; logic [1:0] rt; logic [3:0] be;
  } vec_t;
  // rt: 0 address register, 1 configuration, 2 plain I/O
  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        2'd0, 4'hF},
    '{1'b1, 16'h0CFC, 2'd2, 32'h11223344, 2'd2, 4'hF},
    '{1'b1, 16'h0CF8, 2'd2, 32'h8000F8F0, 2'd0, 4'hF},
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        2'd0, 4'hF},
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,        2'd1, 4'hF},
    '{1'b0, 16'h0CFE, 2'd0, 32'h0,        2'd1, 4'h4},
    '{1'b0, 16'h0CFE, 2'd1, 32'h0,        2'd1, 4'hC},
    '{1'b1, 16'h0CFD, 2'd0, 32'h0000AB00, 2'd1, 4'h2},
    '{1'b1, 16'h0CF8, 2'd2, 32'h7FFFFFFF, 2'd0, 4'hF},
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        2'd0, 4'hF},
    '{1'b0, 16'h0CFC, 2'd1, 32'h0,        2'd2, 4'h3},
    '{1'b1, 16'h0CF8, 2'd0, 32'h00000080, 2'd2, 4'h1},
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        2'd0, 4'hF},
    '{1'b1, 16'h0CF8, 2'd2, 32'h81231234, 2'd0, 4'hF},
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,        2'd1, 4'hF},
    '{1'b0, 16'h0080, 2'd0, 32'h0,        2'd2, 4'h1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] shadow, rd, exp;
    int c0, i0;
    shadow = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(host_req_ready && !cfg_req_valid && !io_req_valid && !host_rsp_valid,
          "R1 idle after reset", {28'b0, host_req_ready, cfg_req_valid, io_req_valid, host_rsp_valid}, 32'h8);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      c0 = cfg_cnt; i0 = io_cnt;
      access(v.w, v.port, v.sz, v.wd, 0, rd);
      @(negedge clk);
      exp = 32'h0;
      if (v.rt == 2'd0) begin
        check(cfg_cnt == c0 && io_cnt == i0, "R2 address register local", cfg_cnt + io_cnt, c0 + i0);
        if (v.w) shadow = {v.wd[31], 7'b0, v.wd[23:2], 2'b00};
        else exp = shadow;
        check(rd == exp, "R1/R2 address register read", rd, exp);
      end else if (v.rt == 2'd1) begin
        check(cfg_cnt == c0 + 1 && io_cnt == i0, "R4 one config request", cfg_cnt, c0 + 1);
        check(l_cw == v.w && (!v.w || l_cwd == v.wd), "R4 write flag and data", l_cwd, v.wd);
        check({l_bus, l_dev, l_fn, l_idx} == {shadow[23:16], shadow[15:11], shadow[10:8], shadow[7:2]},
              "R3 target fields", {10'b0, l_bus, l_dev, l_fn, l_idx},
              {10'b0, shadow[23:16], shadow[15:11], shadow[10:8], shadow[7:2]});
        check(l_cbe == v.be, "R5 config byte enables", {28'b0, l_cbe}, {28'b0, v.be});
        if (!v.w) exp = (shadow[23:16] == 8'd0) ? dev_model(shadow[23:16], shadow[15:11], shadow[10:8], shadow[7:2])
                                               : 32'hFFFFFFFF;
        check(rd == exp, "R8 config read data", rd, exp);
      end else begin
        check(io_cnt == i0 + 1 && cfg_cnt == c0, "R6/R7 plain I/O forward", io_cnt, i0 + 1);
        check(l_port == v.port && l_iw == v.w && (!v.w || l_iwd == v.wd), "R6 port/data kept",
              {16'b0, l_port}, {16'b0, v.port});
        check(l_ibe == v.be, "R5 I/O byte enables", {28'b0, l_ibe}, {28'b0, v.be});
        if (!v.w) exp = {16'hD00D, v.port};
        check(rd == exp, "R8 I/O read data", rd, exp);
      end
    end

    // R9: stalled configuration request, host not accepted meanwhile
    access(1'b1, 16'h0CF8, 2'd2, 32'h80000810, 0, rd);
    @(negedge clk);
    cfg_req_ready = 0;
    c0 = cfg_cnt;
    fork
      access(1'b0, 16'h0CFC, 2'd2, 32'h0, 3, rd);
      begin
        repeat (4) @(negedge clk);
        check(cfg_req_valid && !host_req_ready && cfg_cnt == c0, "R9 request held while stalled",
              {30'b0, cfg_req_valid, host_req_ready}, 32'h2);
        check(cfg_req_be == 4'hF && cfg_req_idx == 6'h04, "R9 payload stable",
              {26'b0, cfg_req_idx}, 32'h4);
        cfg_req_ready = 1;
      end
    join
    exp = dev_model(8'd0, 5'd1, 3'd0, 6'h04);
    check(rd == exp, "R8 read after stall", rd, exp);

    // R1: reset clears the enable bit mid-run
    access(1'b1, 16'h0CF8, 2'd2, 32'h80000000, 0, rd);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    access(1'b0, 16'h0CF8, 2'd2, 32'h0, 0, rd);
    check(rd == 32'h0, "R1 register cleared by reset", rd, 32'h0);
    c0 = cfg_cnt; i0 = io_cnt;
    access(1'b0, 16'h0CFF, 2'd0, 32'h0, 0, rd);
    @(negedge clk);
    check(io_cnt == i0 + 1 && cfg_cnt == c0, "R1/R6 forwarded after reset", io_cnt, i0 + 1);
    check(l_ibe == 4'h8, "R5 top byte lane", {28'b0, l_ibe}, 32'h8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule